// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Counter

This block is the second protection tier behind a cycle-by-cycle current limiter in a switching regulator controller. Every switching period it receives a strobe together with a flag saying whether the limiter cut that period's pulse short. A saturating up/down count weighs periods that had an overcurrent event against clean periods. When the count reaches the trip threshold, the block declares a fault, turns the PWM off and commands both gate drivers into their off state.

While the fault stands, the block asks for soft-start ramps to run with the drivers idle. Each completed ramp lowers the count by one, so the hiccup lasts as many ramps as the trip threshold. When the count returns to zero, the PWM is enabled again and a normal restart follows. If the short is still present, the count climbs back and the cycle repeats. A single parameter sets both the trip threshold and the hiccup length.

Top module: `hiccup_fault_counter`

## Requirements
- R1: After reset, pwmEnable is 1, and faultActive, driversOff and softStartReq are 0. The internal count is zero.
- R2: In normal mode, a cycleStrobe with overCurrent high adds one to the count. The strobe that brings the count to TRIP_COUNT (default 7) puts the block into fault mode, visible on the outputs right after that clock edge.
- R3: In normal mode, a cycleStrobe with overCurrent low subtracts one from a nonzero count. Overcurrent and clean periods therefore net against each other.
- R4: In normal mode, the count saturates at zero. Clean periods at zero leave it at zero, so exactly TRIP_COUNT further overcurrent periods are needed to trip.
- R5: In fault mode, pwmEnable is 0, and faultActive, driversOff and softStartReq are 1.
- R6: In fault mode, cycleStrobe and overCurrent have no effect on the count or on the outputs.
- R7: In fault mode, each ssDone strobe subtracts one from the count. The ssDone that brings the count to zero returns the block to normal mode, which shows as pwmEnable 1 right after that edge.
- R8: In normal mode, ssDone has no effect.
- R9: overCurrent without cycleStrobe in the same cycle has no effect.
- R10: After a restart, a persisting overcurrent re-enters fault mode after exactly TRIP_COUNT overcurrent periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStrobe | input | 1 | One-cycle pulse at the end of each switching period |
| overCurrent | input | 1 | The period ending at this strobe had an overcurrent cutoff |
| ssDone | input | 1 | One-cycle pulse when a soft-start ramp completes |
| pwmEnable | output | 1 | PWM allowed to switch |
| faultActive | output | 1 | Hiccup fault in progress |
| driversOff | output | 1 | Force both gate drivers to their off state |
| softStartReq | output | 1 | Run idle soft-start ramps |

## Verification
The assertions take for granted that cycleStrobe and ssDone are single-cycle strobes whose timing carries no meaning beyond the mode they arrive in. They also rely on the count being changed only through increment and decrement commands issued by the control logic. The stimulus drives all three inputs freely, including overCurrent without a strobe, ssDone in normal mode, and strobes during fault. This exercises every case the control must ignore, while a behavioural model predicts each output cycle by cycle.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic {
    HC_NORMAL = 1'b0,
    HC_FAULT  = 1'b1
  } hcState_t;

  typedef struct packed {
    logic inc;
    logic dec;
  } cntCmd_t;
endpackage

// File: rtl/hiccup_count_path.sv
module hiccup_count_path
  import hiccup_pkg::*;
#(
  parameter int TRIP_COUNT = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    cntWillTrip,
  output logic    cntIsOne,
  output logic    cntIsZero
);
  localparam int CW = $clog2(TRIP_COUNT + 1);
  localparam logic [CW-1:0] TRIP_V = CW'(TRIP_COUNT);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)        cntQ <= '0;
    else if (cmd.inc) cntQ <= cntQ + ONE_V;
    else if (cmd.dec) cntQ <= cntQ - ONE_V;
  end

  assign cntWillTrip = (cntQ == TRIP_V - ONE_V);
  assign cntIsOne    = (cntQ == ONE_V);
  assign cntIsZero   = (cntQ == '0);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inc |-> (cntQ < TRIP_V));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> (cntQ != '0));
  assert_single_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.inc && cmd.dec));
  assert_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= TRIP_V);
endmodule

// File: rtl/hiccup_control.sv
module hiccup_control
  import hiccup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycleStrobe,
  input  logic    overCurrent,
  input  logic    ssDone,
  input  logic    cntWillTrip,
  input  logic    cntIsOne,
  input  logic    cntIsZero,
  output cntCmd_t cmd,
  output logic    pwmEnable,
  output logic    faultActive,
  output logic    driversOff,
  output logic    softStartReq
);
  hcState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    cmd.inc = 1'b0;
    cmd.dec = 1'b0;
    unique case (stateQ)
      HC_NORMAL: begin
        if (cycleStrobe) begin
          if (overCurrent) begin
            cmd.inc = 1'b1;
            if (cntWillTrip) stateD = HC_FAULT;
          end else if (!cntIsZero) begin
            cmd.dec = 1'b1;
          end
        end
      end
      HC_FAULT: begin
        if (ssDone) begin
          cmd.dec = 1'b1;
          if (cntIsOne) stateD = HC_NORMAL;
        end
      end
      default: stateD = HC_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= HC_NORMAL;
    else       stateQ <= stateD;
  end

  assign faultActive  = (stateQ == HC_FAULT);
  assign pwmEnable    = !faultActive;
  assign driversOff   = faultActive;
  assign softStartReq = faultActive;

  assert_fault_ignores_cycles_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == HC_FAULT) |-> !cmd.inc);
  assert_fault_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == HC_FAULT && !ssDone) |=> (stateQ == HC_FAULT));
  assert_exit_on_last_ramp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == HC_FAULT && ssDone && cntIsOne) |=> (stateQ == HC_NORMAL));
  assert_normal_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == HC_NORMAL && !cycleStrobe) |=> (stateQ == HC_NORMAL));
  assert_trip_on_threshold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == HC_NORMAL && cycleStrobe && overCurrent && cntWillTrip) |=> (stateQ == HC_FAULT));
endmodule

// File: rtl/hiccup_fault_counter.sv
module hiccup_fault_counter
  import hiccup_pkg::*;
#(
  parameter int TRIP_COUNT = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleStrobe,
  input  logic overCurrent,
  input  logic ssDone,
  output logic pwmEnable,
  output logic faultActive,
  output logic driversOff,
  output logic softStartReq
);
  cntCmd_t cmd;
  logic cntWillTrip, cntIsOne, cntIsZero;

  hiccup_control ctrl_i (
    .clk(clk), .rstN(rstN),
    .cycleStrobe(cycleStrobe), .overCurrent(overCurrent), .ssDone(ssDone),
    .cntWillTrip(cntWillTrip), .cntIsOne(cntIsOne), .cntIsZero(cntIsZero),
    .cmd(cmd),
    .pwmEnable(pwmEnable), .faultActive(faultActive),
    .driversOff(driversOff), .softStartReq(softStartReq)
  );

  hiccup_count_path #(.TRIP_COUNT(TRIP_COUNT)) cnt_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .cntWillTrip(cntWillTrip), .cntIsOne(cntIsOne), .cntIsZero(cntIsZero)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (pwmEnable && !faultActive));
endmodule

// File: tb/hiccup_fault_counter_tb_top.sv
`timescale 1ns/1ps
module hiccup_fault_counter_tb_top;
  localparam int TRIP = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStrobe = 1'b0, overCurrent = 1'b0, ssDone = 1'b0;
  logic pwmEnable, faultActive, driversOff, softStartReq;

  int checks = 0;
  int failures = 0;
  int mCnt = 0;
  bit mFault = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hiccup_fault_counter #(.TRIP_COUNT(TRIP)) dut_i (
    .clk(clk), .rstN(rstN),
    .cycleStrobe(cycleStrobe), .overCurrent(overCurrent), .ssDone(ssDone),
    .pwmEnable(pwmEnable), .faultActive(faultActive),
    .driversOff(driversOff), .softStartReq(softStartReq)
  );

  task automatic compare(string req);
    logic [3:0] act, exp;
    act = {pwmEnable, faultActive, driversOff, softStartReq};
    exp = mFault ? 4'b0111 : 4'b1000;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: outputs {pwm,fault,drvOff,ssReq} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(bit cs, bit oc, bit ss, string req);
    cycleStrobe = cs; overCurrent = oc; ssDone = ss;
    @(posedge clk);
    if (!mFault) begin
      if (cs && oc) begin
        mCnt++;
        if (mCnt == TRIP) mFault = 1'b1;
      end else if (cs && mCnt > 0) begin
        mCnt--;
      end
    end else if (ss) begin
      mCnt--;
      if (mCnt == 0) mFault = 1'b0;
    end
    @(negedge clk);
    cycleStrobe = 1'b0; overCurrent = 1'b0; ssDone = 1'b0;
    compare(req);
  endtask

  task automatic expectFault(bit f, string req);
    checks++;
    if (faultActive !== f) begin
      failures++;
      $display("FAIL %s: faultActive actual=%b expected=%b", req, faultActive, f);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    // R2 / R3 netting: 3 oc, 2 clean, then need 6 more oc
    for (int i = 0; i < 3; i++) step(1, 1, 0, "R2");
    for (int i = 0; i < 2; i++) step(1, 0, 0, "R3");
    for (int i = 0; i < TRIP - 2; i++) step(1, 1, 0, "R3");
    expectFault(1'b0, "R3");
    step(1, 1, 0, "R2");
    expectFault(1'b1, "R2");
    compare("R5");
    // R6: strobes ignored in fault
    for (int i = 0; i < 10; i++) step(1, i % 2, 0, "R6");
    expectFault(1'b1, "R6");
    // R7: TRIP ramps exit
    for (int i = 0; i < TRIP - 1; i++) step(0, 0, 1, "R7");
    expectFault(1'b1, "R7");
    step(0, 0, 1, "R7");
    expectFault(1'b0, "R7");
    // R8 ssDone in normal; R9 oc without strobe
    for (int i = 0; i < 5; i++) step(0, 0, 1, "R8");
    for (int i = 0; i < 20; i++) step(0, 1, 0, "R9");
    expectFault(1'b0, "R9");
    // R4 saturation at zero
    for (int i = 0; i < 10; i++) step(1, 0, 0, "R4");
    for (int i = 0; i < TRIP - 1; i++) step(1, 1, 0, "R4");
    expectFault(1'b0, "R4");
    step(1, 1, 0, "R4");
    expectFault(1'b1, "R4");
    // R10 restart into persisting short
    for (int i = 0; i < TRIP; i++) step(0, 0, 1, "R7");
    for (int i = 0; i < TRIP - 1; i++) step(1, 1, 0, "R10");
    expectFault(1'b0, "R10");
    step(1, 1, 0, "R10");
    expectFault(1'b1, "R10");
    // Mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0),
           1'($urandom_range(0, 2) == 0), "R2/R3/R6/R7 mixed");
    // R1: reset mid-fault
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    mCnt = 0; mFault = 1'b0;
    rstN = 1'b1;
    compare("R1");
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule